// File: doc/BRIEF.md
# Touch-Key Register Selector

This block sits behind a row of sixteen touch keys, one for each CPU register (numbers 0 to 15). When exactly one key is held, the block turns it into a 4-bit register number. It then waits a settling delay and opens a timed capture window. If the same single-key condition still holds when the window closes, the number is stored in a selection register.

The stored number drives two outputs. The first is a one-hot, active-low indicator bus, with one bit per register, that lights only the chosen register. The second is an active-low 4-bit register-address field that feeds a downstream address multiplexer.

Three conditions stop a capture. Two or more keys held together block it. Releasing the key before the window closes aborts it. After a capture, the keys must go fully idle before another sequence can begin. Both timing intervals are counted in clock cycles, and their default lengths are derived from a clock-frequency parameter.

Top module: `touch_reg_select`

## Requirements
- R1: While `mrst_n` is low at a rising clock edge, the selection is set to register 0 at that edge: `led_n` = 16'hFFFE and `reg_addr_n` = 4'hF.
- R2: Key input bit k (0..15) is register k. Holding only that key for a full sequence stores the number k.
- R3: Counting from the first clock edge that sees a key, the outputs do not change during the first SETTLE_CYC + STROBE_CYC edges. When the sequence completes, the new value appears at edge SETTLE_CYC + STROBE_CYC + 3.
- R4: If two or more key bits are high at any time during the settle or capture interval, nothing is stored and the previous selection is kept.
- R5: If every key is released before the capture window closes, the sequence aborts and the selection is unchanged.
- R6: After a capture, no new capture starts until all keys have been released. Moving straight from one key to another without an idle cycle stores nothing new.
- R7: `led_n` is active low and one-hot. Only bit n is 0, where n is the stored register number.
- R8: `reg_addr_n` is the bitwise complement of the stored register number.
- R9: SETTLE_CYC defaults to CLK_HZ*19/10000 (about 1.9 ms) and STROBE_CYC defaults to CLK_HZ*34/10000 (about 3.4 ms).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| mrst_n | input | 1 | Synchronous master reset, active low |
| keys | input | 16 | Touch-key lines, one per register, high when touched |
| reg_addr_n | output | 4 | Stored register number, active low, to the address multiplexer |
| led_n | output | 16 | Register indicator lines, active low, one-hot |

## Verification
Several properties are checked on every cycle by assertions:
- the indicator bus always agrees with the address field;
- the selection changes only on a load strobe;
- a load follows a single clean key;
- the capture window opens only after a full settle count;
- nothing loads while the sequencer waits for a release or after a key drops.

Other behaviour can only be shown by the bench scenarios:
- that each of the sixteen keys stores its own number;
- the exact edge at which the outputs move;
- that mid-window aborts, multi-key presses and key slides leave the old selection in place.

// File: rtl/touch_reg_select_pkg.sv
package touch_reg_select_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SETTLE = 2'd1,
    SQ_STROBE = 2'd2,
    SQ_HOLD  = 2'd3
  } seq_state_t;

endpackage

// File: rtl/key_encoder.sv
module key_encoder #(
  parameter int N_KEYS = 16,
  parameter int NW     = $clog2(N_KEYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_KEYS-1:0] keys,
  output logic [NW-1:0]     code,
  output logic              any_key,
  output logic              multi_key
);

  logic [NW-1:0] code_c;

  // lowest-numbered active key wins; the value is unused when multi_key is set
  always_comb begin
    code_c = '0;
    for (int i = N_KEYS - 1; i >= 0; i--) begin
      if (keys[i]) code_c = i[NW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code      <= '0;
      any_key   <= 1'b0;
      multi_key <= 1'b0;
    end else begin
      code      <= code_c;
      any_key   <= |keys;
      multi_key <= ($countones(keys) > 1);
    end
  end

  // R4: the multi flag never rises without the any-key flag
  p_multi_implies_any_r4: assert property (@(posedge clk) disable iff (rst)
    multi_key |-> any_key);

endmodule

// File: rtl/capture_sequencer.sv
module capture_sequencer
  import touch_reg_select_pkg::*;
#(
  parameter int NW         = 4,
  parameter int SETTLE_CYC = 1900,
  parameter int STROBE_CYC = 3400,
  localparam int MAXC      = (SETTLE_CYC > STROBE_CYC) ? SETTLE_CYC : STROBE_CYC,
  localparam int CW        = $clog2(MAXC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] code,
  input  logic          any_key,
  input  logic          multi_key,
  output logic          load,
  output logic [NW-1:0] load_code
);

  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] STROBE_LAST = CW'(STROBE_CYC - 1);

  seq_state_t    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      cnt       <= '0;
      load      <= 1'b0;
      load_code <= '0;
    end else begin
      load <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          cnt <= '0;
          if (any_key) state <= multi_key ? SQ_HOLD : SQ_SETTLE;
        end
        SQ_SETTLE: begin
          if (!any_key) begin
            state <= SQ_IDLE;
          end else if (multi_key) begin
            state <= SQ_HOLD;
          end else if (cnt == SETTLE_LAST) begin
            state <= SQ_STROBE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_STROBE: begin
          if (!any_key) begin
            state <= SQ_IDLE;
          end else if (multi_key) begin
            state <= SQ_HOLD;
          end else if (cnt == STROBE_LAST) begin
            state     <= SQ_HOLD;
            load      <= 1'b1;
            load_code <= code;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_HOLD: begin
          cnt <= '0;
          if (!any_key) state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R4: a load follows a cycle with exactly one key seen
  p_load_single_key_r4: assert property (@(posedge clk) disable iff (rst)
    load |-> $past(any_key && !multi_key));

  // R3: the capture window opens only after a full settle count
  p_window_after_settle_r3: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_SETTLE && cnt != SETTLE_LAST && any_key) |=> state != SQ_STROBE);

  // R6: while waiting for release with a key held, no load and no restart
  p_hold_until_release_r6: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_HOLD && any_key) |=> (state == SQ_HOLD && !load));

  // R5: a dropped key in settle or strobe never produces a load
  p_abort_no_load_r5: assert property (@(posedge clk) disable iff (rst)
    ((state == SQ_SETTLE || state == SQ_STROBE) && !any_key) |=> !load);

endmodule

// File: rtl/select_register.sv
module select_register #(
  parameter int N_KEYS = 16,
  parameter int NW     = $clog2(N_KEYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [NW-1:0]     load_code,
  output logic [NW-1:0]     addr_n,
  output logic [N_KEYS-1:0] led_n
);

  logic [NW-1:0] sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel    <= '0;
      addr_n <= '1;
    end else if (load) begin
      sel    <= load_code;
      addr_n <= ~load_code;
    end
  end

  for (genvar g = 0; g < N_KEYS; g++) begin : g_led
    always_ff @(posedge clk) begin
      if (rst)       led_n[g] <= (g != 0);
      else if (load) led_n[g] <= (load_code != NW'(g));
    end
  end

  // R3: the selection moves only on a load strobe
  p_sel_only_on_load_r3: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(sel));

endmodule

// File: rtl/touch_reg_select.sv
module touch_reg_select #(
  parameter int CLK_HZ     = 1_000_000,
  parameter int N_KEYS     = 16,
  parameter int SETTLE_CYC = CLK_HZ * 19 / 10000,
  parameter int STROBE_CYC = CLK_HZ * 34 / 10000,
  localparam int NW        = $clog2(N_KEYS)
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic [N_KEYS-1:0] keys,
  output logic [NW-1:0]     reg_addr_n,
  output logic [N_KEYS-1:0] led_n
);

  logic          rst;
  logic [NW-1:0] enc_code;
  logic          enc_any;
  logic          enc_multi;
  logic          load;
  logic [NW-1:0] load_code;

  assign rst = !mrst_n;

  key_encoder #(.N_KEYS(N_KEYS), .NW(NW)) u_enc (
    .clk       (clk),
    .rst       (rst),
    .keys      (keys),
    .code      (enc_code),
    .any_key   (enc_any),
    .multi_key (enc_multi)
  );

  capture_sequencer #(.NW(NW), .SETTLE_CYC(SETTLE_CYC), .STROBE_CYC(STROBE_CYC)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .code      (enc_code),
    .any_key   (enc_any),
    .multi_key (enc_multi),
    .load      (load),
    .load_code (load_code)
  );

  select_register #(.N_KEYS(N_KEYS), .NW(NW)) u_sel (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_code (load_code),
    .addr_n    (reg_addr_n),
    .led_n     (led_n)
  );

  // R1: reset returns the selection to register 0
  p_reset_zero_r1: assert property (@(posedge clk)
    !mrst_n |=> (reg_addr_n == '1 && led_n == {{(N_KEYS-1){1'b1}}, 1'b0}));

  // R7 / R8: indicator bus is one-hot low and agrees with the address field
  p_led_onehot_r7: assert property (@(posedge clk) disable iff (!mrst_n)
    $countones(~led_n) == 1);
  p_led_matches_addr_r8: assert property (@(posedge clk) disable iff (!mrst_n)
    led_n[~reg_addr_n] == 1'b0);

endmodule

// File: tb/tb_touch_reg_select.sv
module tb_touch_reg_select;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 10000;
  localparam int SETTLE     = CLK_HZ * 19 / 10000;
  localparam int STROBE     = CLK_HZ * 34 / 10000;
  localparam int SEQ        = SETTLE + STROBE;

  logic        clk = 1'b0;
  logic        mrst_n = 1'b0;
  logic [15:0] keys = '0;
  logic [3:0]  reg_addr_n;
  logic [15:0] led_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  touch_reg_select #(.CLK_HZ(CLK_HZ)) dut (
    .clk        (clk),
    .mrst_n     (mrst_n),
    .keys       (keys),
    .reg_addr_n (reg_addr_n),
    .led_n      (led_n)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_sel(input int n, input string req);
    logic [15:0] e_led;
    logic [3:0]  e_addr;
    e_led  = ~(16'h1 << n);
    e_addr = ~4'(n);
    checks++;
    if (led_n !== e_led || reg_addr_n !== e_addr) begin
      errors++;
      $display("FAIL %s: led_n=%h addr_n=%h expected led_n=%h addr_n=%h",
               req, led_n, reg_addr_n, e_led, e_addr);
    end
  endtask

  task automatic capture(input int k);
    keys = 16'h1 << k;
    cyc(SEQ + 6);
    keys = '0;
    cyc(3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    expect_sel(0, "R1 reset");
    mrst_n = 1'b1;
    cyc(2);
    expect_sel(0, "R1 after reset");

    // R2 / R7 / R8: every key in turn
    for (int k = 15; k >= 0; k--) begin
      capture(k);
      expect_sel(k, "R2 R7 R8 key sweep");
    end

    // R3: exact timing of the update (R9 defaults give SETTLE=19, STROBE=34)
    keys = 16'h0020;
    cyc(SEQ);
    expect_sel(0, "R3 before window end");
    cyc(4);
    expect_sel(5, "R3 after window end");
    keys = '0;
    cyc(3);

    // R5: release in the middle of the window
    keys = 16'h0200;
    cyc(SETTLE + STROBE / 2);
    keys = '0;
    cyc(SEQ);
    expect_sel(5, "R5 abort in window");

    // R5: release during settle
    keys = 16'h0400;
    cyc(SETTLE / 2);
    keys = '0;
    cyc(SEQ);
    expect_sel(5, "R5 abort in settle");

    // R4: two keys from the start, for every adjacent pair
    for (int k = 0; k < 15; k++) begin
      keys = (16'h1 << k) | (16'h1 << (k + 1));
      cyc(SEQ + 10);
      keys = '0;
      cyc(3);
      expect_sel(5, "R4 two keys");
    end

    // R4: second key joins during settle, then lone key stays
    keys = 16'h0008;
    cyc(5);
    keys = 16'h8008;
    cyc(3);
    keys = 16'h0008;
    cyc(SEQ + 10);
    expect_sel(5, "R4 multi mid-sequence");
    keys = '0;
    cyc(3);

    // R6: slide from one key to another without release
    keys = 16'h0080;
    cyc(SEQ + 6);
    expect_sel(7, "R6 first capture");
    keys = 16'h1000;
    cyc(SEQ + 10);
    expect_sel(7, "R6 slide ignored");
    keys = '0;
    cyc(3);
    capture(12);
    expect_sel(12, "R6 re-press captured");

    // R1: reset mid-selection
    mrst_n = 1'b0;
    cyc(2);
    expect_sel(0, "R1 reset clears");
    mrst_n = 1'b1;
    cyc(2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule